// File: doc/BRIEF.md
# Sample-Rate Distortion Stage

This block shapes one signed 24-bit audio sample in every period of the sample clock. First it limits the sample to a symmetric threshold. The threshold drops as an 8-bit Drive setting rises, so harder drive gives more squared-off peaks. The limited value then passes through a gain stage whose multiplier comes from an 8-bit Volume setting. The gain mutes at Volume 0, gives exactly unity at 127 and climbs to about +10 dB at 255. The scaled result saturates to the signed 24-bit range, so it never wraps.

The surrounding audio path pulses `strobe_i` for one clock cycle when a new sample is present, and the unit registers its result on that edge. When `en_i` is low, the registered result is the raw input sample, which bypasses the stage. The limited and scaled intermediate values are brought out as combinational ports so that each stage can be observed on its own.

Top module: `distortion_unit`

## Requirements
- R1: While `rst_n` is low, and after reset until the first strobe, `sample_o` is 0.
- R2: With threshold T = 8388607 − 16448·D, where D is `drive_i` read as unsigned (0..255), a two's-complement `sample_i` greater than T gives `clip_o` = T. Any value from −T to T passes to `clip_o` unchanged.
- R3: A sample below −T gives `clip_o` = −T. The limit is symmetric and never wraps: 0x800000 with D = 8 gives a value above 0x800000, and 0x7FFFFF with D = 0 is left unchanged.
- R4: `volume_i` = 0 forces `boost_o` to 0 for every sample.
- R5: `volume_i` = 127 gives a gain of exactly 1, so `boost_o` equals `clip_o`.
- R6: For volume V in 1..126, let e = 127 − V. The multiplier is G = ((16 − (e mod 16)/2) · (4096 >> (e/16))) >> 4, with integer division. `boost_o` is floor(`clip_o`·G / 4096).
- R7: For V in 128..255, let k = V − 127. The multiplier is G = 4096 + ((69·k·k) >> 7), which reaches 12928 (about 3.16×) at V = 255. `boost_o` is computed from G in the same way as in R6.
- R8: A scaled value above 8388607 or below −8388608 saturates to 0x7FFFFF or 0x800000 respectively.
- R9: If `en_i` is low on a strobe edge, `sample_o` takes `sample_i` unchanged.
- R10: On a rising clock edge with `strobe_i` high and `en_i` high, `sample_o` takes `boost_o`. At edges without a strobe, `sample_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_i | input | 1 | One-cycle pulse marking a new sample |
| en_i | input | 1 | 1 = apply distortion, 0 = bypass |
| sample_i | input | 24 | Signed input sample |
| drive_i | input | 8 | Clip drive setting, unsigned |
| volume_i | input | 8 | Output gain setting, unsigned |
| sample_o | output | 24 | Registered processed sample |
| clip_o | output | 24 | Combinational limited value |
| boost_o | output | 24 | Combinational scaled and saturated value |

## Verification
`clip_o` and `boost_o` are purely combinational, so they are valid in the same cycle the inputs settle. `sample_o` changes at the first rising edge on which `strobe_i` is high. The bench drives every stimulus on a falling edge with the strobe raised, then drops the strobe on the next falling edge. At that point it compares all three outputs, one register delay after the stimulus, while the inputs are still held. For the hold rule, the bench changes the inputs without a strobe, lets several edges pass, and then samples `sample_o` again.

// File: rtl/dist_pkg.sv
// Package: shared widths and the Volume-to-multiplier mapping.
// Assumes 8-bit control values with unity gain at code 127.
package dist_pkg;
    localparam int SAMPLE_W   = 24;
    localparam int CTRL_W     = 8;
    localparam int GAIN_W     = 14;   // unsigned multiplier width
    localparam int GAIN_FRAC  = 12;   // fractional bits, unity = 4096
    localparam int DRIVE_STEP = 16448;
    localparam int VOL_MID    = 127;

    // Multiplier for a volume code: mute, exponential-style cut, rising boost.
    function automatic int gain_code(input int v);
        int e;
        int k;
        int unity;
        unity = 1 << GAIN_FRAC;
        if (v == 0) begin
            return 0;
        end else if (v <= VOL_MID) begin
            e = VOL_MID - v;
            return ((16 - (e % 16) / 2) * (unity >> (e / 16))) >> 4;
        end else begin
            k = v - VOL_MID;
            return unity + ((69 * k * k) >> 7);
        end
    endfunction
endpackage

// File: rtl/dist_clipper.sv
// Symmetric limiter: threshold = max positive - DRIVE_STEP * drive.
// Assumes the threshold stays positive for every drive code.
module dist_clipper
    import dist_pkg::*;
#(
    parameter int W      = SAMPLE_W,
    parameter int CW     = CTRL_W,
    parameter int STEP   = DRIVE_STEP
) (
    input  logic [W-1:0]  x_i,
    input  logic [CW-1:0] drive_i,
    output logic [W-1:0]  y_o
);
    localparam int EXT_W = W + 2;
    localparam logic signed [EXT_W-1:0] MAXPOS = EXT_W'((longint'(1) <<< (W - 1)) - 1);
    localparam logic signed [EXT_W-1:0] STEP_X = EXT_W'(STEP);

    logic signed [EXT_W-1:0] th;
    logic signed [EXT_W-1:0] x_ext;
    logic signed [EXT_W-1:0] neg_th;

    // Threshold and sign-extended sample.
    always_comb begin
        th     = MAXPOS - STEP_X * $signed(EXT_W'(drive_i));
        neg_th = -th;
        x_ext  = EXT_W'($signed(x_i));
    end

    // Limit against the positive and negative threshold.
    always_comb begin
        if (x_ext > th)          y_o = th[W-1:0];
        else if (x_ext < neg_th) y_o = neg_th[W-1:0];
        else                     y_o = x_i;
    end
endmodule

// File: rtl/dist_gain_lut.sv
// Lookup of fixed-point multipliers, one per volume code, built at elaboration.
// Assumes each code fits in GW unsigned bits.
module dist_gain_lut
    import dist_pkg::*;
#(
    parameter int CW = CTRL_W,
    parameter int GW = GAIN_W
) (
    input  logic [CW-1:0] vol_i,
    output logic [GW-1:0] gain_o
);
    localparam int ENTRIES = 1 << CW;

    logic [GW-1:0] table_q [ENTRIES];

    // One constant entry per volume code.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        assign table_q[i] = GW'(gain_code(i));
    end

    // Select the multiplier for the current code.
    assign gain_o = table_q[vol_i];
endmodule

// File: rtl/dist_driver.sv
// Gain stage: signed sample times unsigned Q.FRAC multiplier, floor, saturate.
// Assumes the product fits W+GW+1 bits (always true by width).
module dist_driver
    import dist_pkg::*;
#(
    parameter int W    = SAMPLE_W,
    parameter int GW   = GAIN_W,
    parameter int FRAC = GAIN_FRAC
) (
    input  logic [W-1:0]  x_i,
    input  logic [GW-1:0] gain_i,
    output logic [W-1:0]  y_o
);
    localparam int PW = W + GW + 1;
    localparam logic signed [PW-1:0] MAXV = PW'((longint'(1) <<< (W - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = -PW'(longint'(1) <<< (W - 1));

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;

    // Multiply and drop the fractional bits (arithmetic shift = floor).
    always_comb begin
        prod   = PW'($signed(x_i)) * $signed({1'b0, gain_i});
        scaled = prod >>> FRAC;
    end

    // Saturate into the signed sample range.
    always_comb begin
        if (scaled > MAXV)      y_o = MAXV[W-1:0];
        else if (scaled < MINV) y_o = MINV[W-1:0];
        else                    y_o = scaled[W-1:0];
    end
endmodule

// File: rtl/distortion_unit.sv
// Top: limiter -> gain stage -> per-strobe output register with bypass.
// Assumes strobe_i is a single-cycle pulse per sample period.
module distortion_unit
    import dist_pkg::*;
#(
    parameter int W  = SAMPLE_W,
    parameter int CW = CTRL_W,
    parameter int GW = GAIN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_i,
    input  logic          en_i,
    input  logic [W-1:0]  sample_i,
    input  logic [CW-1:0] drive_i,
    input  logic [CW-1:0] volume_i,
    output logic [W-1:0]  sample_o,
    output logic [W-1:0]  clip_o,
    output logic [W-1:0]  boost_o
);
    logic [GW-1:0] gain;

    dist_clipper #(.W(W), .CW(CW)) u_clip (
        .x_i     (sample_i),
        .drive_i (drive_i),
        .y_o     (clip_o)
    );

    dist_gain_lut #(.CW(CW), .GW(GW)) u_lut (
        .vol_i  (volume_i),
        .gain_o (gain)
    );

    dist_driver #(.W(W), .GW(GW)) u_drv (
        .x_i    (clip_o),
        .gain_i (gain),
        .y_o    (boost_o)
    );

    // Capture processed or bypassed sample on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        sample_o <= '0;
        else if (strobe_i) sample_o <= en_i ? boost_o : sample_i;
    end
endmodule

// File: rtl/distortion_unit_checker.sv
// Checker: temporal and cross-stage properties of distortion_unit.
module distortion_unit_checker #(
    parameter int W  = 24,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          strobe_i,
    input logic          en_i,
    input logic [W-1:0]  sample_i,
    input logic [CW-1:0] drive_i,
    input logic [CW-1:0] volume_i,
    input logic [W-1:0]  sample_o,
    input logic [W-1:0]  clip_o,
    input logic [W-1:0]  boost_o
);
    int lim;
    always_comb lim = ((1 << (W - 1)) - 1) - 16448 * int'(drive_i);

    p_reset_zero_r1: assert property (@(posedge clk) !rst_n |=> sample_o == '0);
    p_clip_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'($signed(clip_o)) <= lim);
    p_clip_lower_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'($signed(clip_o)) >= -lim);
    p_clip_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clip_o != '0) |-> (clip_o[W-1] == sample_i[W-1]));
    p_mute_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (volume_i == '0) |-> (boost_o == '0));
    p_unity_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (volume_i == CW'(127)) |-> (boost_o == clip_o));
    p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && !en_i) |=> (sample_o == $past(sample_i)));
    p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && en_i) |=> (sample_o == $past(boost_o)));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> $stable(sample_o));
endmodule

bind distortion_unit distortion_unit_checker #(.W(W), .CW(CW)) u_chk (.*);

// File: tb/distortion_unit_bench.sv
// Bench: sweeps drive and volume, compares against arithmetic reference.
module distortion_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stb = 1'b0;
    logic        en = 1'b0;
    logic [23:0] sample = '0;
    logic [7:0]  drive = '0;
    logic [7:0]  vol = '0;
    logic [23:0] sample_o, clip_o, boost_o;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    distortion_unit u_distortion_unit (
        .clk(clk), .rst_n(rst_n), .strobe_i(stb), .en_i(en),
        .sample_i(sample), .drive_i(drive), .volume_i(vol),
        .sample_o(sample_o), .clip_o(clip_o), .boost_o(boost_o)
    );

    function automatic int ref_th(input int d);
        return 8388607 - 16448 * d;
    endfunction

    function automatic logic [23:0] ref_clip(input logic [23:0] x, input int d);
        int xs;
        int th;
        xs = $signed(x);
        th = ref_th(d);
        if (xs > th)       return 24'(th);
        else if (xs < -th) return 24'(-th);
        return x;
    endfunction

    function automatic longint ref_gain(input int v);
        int e;
        int k;
        if (v == 0) return 0;
        if (v <= 127) begin
            e = 127 - v;
            return ((16 - (e % 16) / 2) * (4096 >> (e / 16))) >> 4;
        end
        k = v - 127;
        return 4096 + ((69 * k * k) >> 7);
    endfunction

    function automatic longint ref_scaled(input logic [23:0] c, input int v);
        longint p;
        p = longint'($signed(c)) * ref_gain(v);
        return p >>> 12;
    endfunction

    function automatic logic [23:0] ref_boost(input logic [23:0] c, input int v);
        longint s;
        s = ref_scaled(c, v);
        if (s > 8388607)  return 24'h7FFFFF;
        if (s < -8388608) return 24'h800000;
        return 24'(s);
    endfunction

    task automatic check(input logic [23:0] act, input logic [23:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %06h expected %06h", req, act, exp);
        end
    endtask

    // Drive one strobed sample, then check all outputs one edge later.
    task automatic apply(input logic [23:0] x, input int d, input int v, input logic e);
        logic [23:0] ec;
        logic [23:0] eb;
        longint s;
        string bt;
        @(negedge clk);
        sample = x; drive = 8'(d); vol = 8'(v); en = e; stb = 1'b1;
        @(negedge clk);
        stb = 1'b0;
        ec = ref_clip(x, d);
        eb = ref_boost(ec, v);
        s  = ref_scaled(ec, v);
        check(clip_o, ec, $signed(x) < 0 ? "R3 clip" : "R2 clip");
        if (s > 8388607 || s < -8388608) bt = "R8 saturate";
        else if (v == 0)   bt = "R4 mute";
        else if (v == 127) bt = "R5 unity";
        else if (v < 127)  bt = "R6 cut";
        else               bt = "R7 boost";
        check(boost_o, eb, bt);
        check(sample_o, e ? eb : x, e ? "R10 load" : "R9 bypass");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(sample_o, 24'h0, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(sample_o, 24'h0, "R1 after reset");

        // Point cases stated in the requirements.
        apply(24'h7FFFFF, 0, 127, 1'b1);
        check(clip_o, 24'h7FFFFF, "R3 no change at drive 0");
        apply(24'h800000, 8, 127, 1'b1);
        n_checks++;
        if (!($signed(clip_o) > $signed(24'h800000))) begin
            n_fail++;
            $display("FAIL R3 wrap: actual %06h expected above 800000", clip_o);
        end
        apply(24'h00FFFF, 0, 0, 1'b1);
        check(sample_o, 24'h000000, "R4 mute example");
        apply(24'h00FFFF, 0, 127, 1'b1);
        check(sample_o, 24'h00FFFF, "R5 unity example");

        // Drive sweep around both thresholds.
        for (int d = 0; d < 256; d++) begin
            int th;
            th = ref_th(d);
            apply(24'(th + 1), d, 127, 1'b1);
            apply(24'(th), d, 127, 1'b1);
            apply(24'(-th), d, 127, 1'b1);
            apply(24'(-th - 1), d, 127, 1'b1);
            apply(24'h800000, d, 200, 1'b1);
        end

        // Volume sweep over several sample patterns.
        for (int v = 0; v < 256; v++) begin
            apply(24'h00FFFF, 0, v, 1'b1);
            apply(24'h7FFFFF, 0, v, 1'b1);
            apply(24'h800000, 0, v, 1'b1);
            apply(24'hFFFFFF, 0, v, 1'b1);
            apply(24'hC12345, 64, v, 1'b1);
        end

        // Bypass leaves the raw sample.
        for (int i = 0; i < 16; i++) begin
            apply(24'(i * 24'h111111 + 7), i * 16, i * 17, 1'b0);
        end

        // Hold: change inputs without a strobe.
        apply(24'h123456, 0, 127, 1'b1);
        @(negedge clk);
        sample = 24'hABCDEF; vol = 8'd255; en = 1'b0;
        repeat (4) @(negedge clk);
        check(sample_o, 24'h123456, "R10 hold");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule